// File: doc/BRIEF.md
# Dual-Bus Tri-State Register Bank

This block is a small bank of storage words that sits between two independent bidirectional data buses, called A and B. Each bus has its own register-number input, an active-low load strobe and an active-low drive strobe. While a port's load strobe is low, the addressed word takes its value from that port's bus, and it keeps that value once the strobe returns high. While a port's drive strobe is low, the addressed word is placed on that port's bus. At all other times the bus is released to high impedance.

There is no system clock. All sequencing comes from the strobes, so the bus master must follow a fixed protocol. It leaves the bus released at the start of a bus cycle. It presents data together with the load strobe, raises the strobe, and then keeps the data valid for a while longer. The two ports work independently and may both act in the same bus cycle. A word written through one bus can be read through either bus. An active-low reset clears every word.

Top module: `dual_bus_regset`

## Requirements
- R1: The bank holds NUM_REGS words (default 4) of DATA_W bits (default 8). On each port, the binary register number k (00, 01, 10, 11 by default) selects word k.
- R2: While `ld_a_n` is low, the word addressed by `sel_a` follows `bus_a`. The value present when `ld_a_n` rises is held afterwards.
- R3: While `ld_b_n` is low, the word addressed by `sel_b` follows `bus_b`. The value present when `ld_b_n` rises is held afterwards.
- R4: A port drives its bus with the addressed word only while its drive strobe is low and its load strobe is high. In every other case the port releases its bus to all-Z.
- R5: Each port decodes its register number into a one-hot select, so exactly one word is addressed.
- R6: A word loaded through either bus reads back unchanged through the same bus and through the other bus.
- R7: When both ports drive in the same bus cycle, each bus carries its own addressed word, including when both address the same word.
- R8: When both ports load the same word in the same bus cycle, the value from bus A is the one kept.
- R9: A port whose load and drive strobes are both low does not drive its own bus. The value on the bus is the one being loaded.
- R10: While `rst_n` is low, every word is zero. After reset, both buses are released until a drive strobe falls.
- R11: A load changes only the addressed word. Every other word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset; clears all words |
| sel_a | input | SEL_W (2) | Register number for port A |
| ld_a_n | input | 1 | Active-low load strobe for port A |
| rd_a_n | input | 1 | Active-low drive strobe for port A |
| bus_a | inout | DATA_W (8) | Bidirectional data bus A |
| sel_b | input | SEL_W (2) | Register number for port B |
| ld_b_n | input | 1 | Active-low load strobe for port B |
| rd_b_n | input | 1 | Active-low drive strobe for port B |
| bus_b | inout | DATA_W (8) | Bidirectional data bus B |

## Verification
Some properties hold whenever the inputs settle, and the assertions check them continuously. The decoder output is always one-hot. An idle port or a loading port never enables its output driver. Reset forces every word to zero. What a word holds after a strobe sequence, the priority of A when both ports load the same word, readback across ports, and leaving unaddressed words untouched all depend on the order of events. Only the bench's bus cycles can show these. The bench runs each bus cycle through the full protocol, checking that the bus is released before the strobes fall, while they are low, and after they rise.

// File: rtl/regset_pkg.sv
`timescale 1ns/1ps
package regset_pkg;
   localparam int unsigned DEF_DATA_W   = 8;
   localparam int unsigned DEF_NUM_REGS = 4;

   // width of a register number for a given bank depth
   function automatic int unsigned sel_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/regset_decode.sv
`timescale 1ns/1ps
module regset_decode #(
   parameter int unsigned NUM_REGS = regset_pkg::DEF_NUM_REGS,
   parameter int unsigned SEL_W    = regset_pkg::sel_width(NUM_REGS)
) (
   input  logic [SEL_W-1:0]    sel,
   output logic [NUM_REGS-1:0] onehot
);
   // one comparator per word
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
      assign onehot[i] = (sel == SEL_W'(i));
   end
endmodule

// File: rtl/regset_word.sv
`timescale 1ns/1ps
module regset_word #(
   parameter int unsigned DATA_W = regset_pkg::DEF_DATA_W
) (
   input  logic              rst_n,
   input  logic              wr_a,
   input  logic              wr_b,
   input  logic [DATA_W-1:0] din_a,
   input  logic [DATA_W-1:0] din_b,
   output logic [DATA_W-1:0] q
);
   // Level-sensitive storage: transparent while a write is open and
   // holding the last value once the strobe closes. Port A wins.
   always_latch begin
      if (!rst_n)    q <= '0;
      else if (wr_a) q <= din_a;
      else if (wr_b) q <= din_b;
   end
endmodule

// File: rtl/regset_port.sv
`timescale 1ns/1ps
module regset_port #(
   parameter int unsigned DATA_W   = regset_pkg::DEF_DATA_W,
   parameter int unsigned NUM_REGS = regset_pkg::DEF_NUM_REGS
) (
   input  logic                             ld_n,
   input  logic                             rd_n,
   input  logic [NUM_REGS-1:0]              onehot,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  words,
   output logic                             oe,
   output logic [DATA_W-1:0]                rdata
);
   // The drive strobe is active low and must be inverted before gating.
   // A port busy loading keeps its own driver off.
   assign oe = ~rd_n & ld_n;

   // AND-OR read selection on the one-hot select
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         rdata = rdata | (words[i] & {DATA_W{onehot[i]}});
      end
   end
endmodule

// File: rtl/dual_bus_regset.sv
`timescale 1ns/1ps
module dual_bus_regset #(
   parameter int unsigned DATA_W   = regset_pkg::DEF_DATA_W,
   parameter int unsigned NUM_REGS = regset_pkg::DEF_NUM_REGS,
   localparam int unsigned SEL_W   = regset_pkg::sel_width(NUM_REGS)
) (
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_a,
   input  logic              ld_a_n,
   input  logic              rd_a_n,
   inout  wire  [DATA_W-1:0] bus_a,
   input  logic [SEL_W-1:0]  sel_b,
   input  logic              ld_b_n,
   input  logic              rd_b_n,
   inout  wire  [DATA_W-1:0] bus_b
);
   // elaboration checks
   if (NUM_REGS < 2) begin : g_bad_depth
      $error("dual_bus_regset: NUM_REGS must be at least 2");
   end
   if ((1 << SEL_W) != NUM_REGS) begin : g_bad_pow2
      $error("dual_bus_regset: NUM_REGS must be a power of two");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("dual_bus_regset: DATA_W must be positive");
   end

   logic [NUM_REGS-1:0]             oh_a, oh_b;
   logic [NUM_REGS-1:0][DATA_W-1:0] words;
   logic                            oe_a, oe_b;
   logic [DATA_W-1:0]               rdata_a, rdata_b;

   regset_decode #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_dec_a (
      .sel(sel_a), .onehot(oh_a));
   regset_decode #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_dec_b (
      .sel(sel_b), .onehot(oh_b));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      logic wr_a, wr_b;
      assign wr_a = oh_a[i] & ~ld_a_n;
      assign wr_b = oh_b[i] & ~ld_b_n;
      regset_word #(.DATA_W(DATA_W)) u_word (
         .rst_n (rst_n),
         .wr_a  (wr_a),
         .wr_b  (wr_b),
         .din_a (bus_a),
         .din_b (bus_b),
         .q     (words[i]));
   end

   regset_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_port_a (
      .ld_n(ld_a_n), .rd_n(rd_a_n), .onehot(oh_a), .words(words),
      .oe(oe_a), .rdata(rdata_a));
   regset_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_port_b (
      .ld_n(ld_b_n), .rd_n(rd_b_n), .onehot(oh_b), .words(words),
      .oe(oe_b), .rdata(rdata_b));

   assign bus_a = oe_a ? rdata_a : {DATA_W{1'bz}};
   assign bus_b = oe_b ? rdata_b : {DATA_W{1'bz}};
endmodule

// File: rtl/regset_chk.sv
`timescale 1ns/1ps
module regset_chk #(
   parameter int unsigned DATA_W   = regset_pkg::DEF_DATA_W,
   parameter int unsigned NUM_REGS = regset_pkg::DEF_NUM_REGS
) (
   input logic                            rst_n,
   input logic                            ld_a_n,
   input logic                            rd_a_n,
   input logic                            ld_b_n,
   input logic                            rd_b_n,
   input logic [NUM_REGS-1:0]             oh_a,
   input logic [NUM_REGS-1:0]             oh_b,
   input logic                            oe_a,
   input logic                            oe_b,
   input logic [NUM_REGS-1:0][DATA_W-1:0] words
);
   always_comb begin
      if (rst_n === 1'b1) begin
         // R5: exactly one word addressed per port
         p_sel_onehot_a_r5: assert ($countones(oh_a) == 1)
            else $error("decoder A not one-hot");
         p_sel_onehot_b_r5: assert ($countones(oh_b) == 1)
            else $error("decoder B not one-hot");
         // R4: no driver without a drive strobe
         p_idle_release_a_r4: assert (!(rd_a_n && oe_a))
            else $error("bus A driven while idle");
         p_idle_release_b_r4: assert (!(rd_b_n && oe_b))
            else $error("bus B driven while idle");
         // R9: a loading port never drives itself
         p_no_selfdrive_a_r9: assert (!(!ld_a_n && oe_a))
            else $error("bus A driven during load");
         p_no_selfdrive_b_r9: assert (!(!ld_b_n && oe_b))
            else $error("bus B driven during load");
      end
      if (rst_n === 1'b0) begin
         // R10: reset clears every word
         p_reset_clear_r10: assert (words == '0)
            else $error("word not cleared in reset");
      end
   end
endmodule

bind dual_bus_regset regset_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
   .rst_n  (rst_n),
   .ld_a_n (ld_a_n),
   .rd_a_n (rd_a_n),
   .ld_b_n (ld_b_n),
   .rd_b_n (rd_b_n),
   .oh_a   (oh_a),
   .oh_b   (oh_b),
   .oe_a   (oe_a),
   .oe_b   (oe_b),
   .words  (words));

// File: tb/test_dual_bus_regset.sv
`timescale 1ns/1ps
module test_dual_bus_regset;
   localparam logic [7:0] REL = 8'hFF;   // released bus reads as pulled up
   localparam logic [1:0] K_IDLE = 2'd0, K_LOAD = 2'd1, K_DRIVE = 2'd2, K_BOTH = 2'd3;
   localparam int NVEC = 12;
   // {a_kind, a_reg, a_val, b_kind, b_reg, b_val}
   localparam logic [23:0] VEC [NVEC] = '{
      {K_LOAD,  2'd0, 8'h11, K_IDLE,  2'd0, 8'h00},   // R2 load via A
      {K_DRIVE, 2'd0, 8'h00, K_IDLE,  2'd0, 8'h00},   // R2 readback
      {K_IDLE,  2'd0, 8'h00, K_LOAD,  2'd1, 8'h22},   // R3 load via B
      {K_IDLE,  2'd0, 8'h00, K_DRIVE, 2'd1, 8'h00},   // R3 readback
      {K_LOAD,  2'd2, 8'h33, K_LOAD,  2'd3, 8'h44},   // both ports load
      {K_DRIVE, 2'd3, 8'h00, K_DRIVE, 2'd2, 8'h00},   // R6 cross read, R7
      {K_DRIVE, 2'd1, 8'h00, K_DRIVE, 2'd0, 8'h00},   // R6 cross read
      {K_LOAD,  2'd1, 8'h55, K_DRIVE, 2'd0, 8'h00},   // R11 other word kept
      {K_DRIVE, 2'd1, 8'h00, K_DRIVE, 2'd1, 8'h00},   // R7 same word
      {K_DRIVE, 2'd2, 8'h00, K_DRIVE, 2'd3, 8'h00},   // R11 untouched
      {K_IDLE,  2'd0, 8'h00, K_LOAD,  2'd0, 8'h66},   // R3 overwrite
      {K_DRIVE, 2'd0, 8'h00, K_IDLE,  2'd0, 8'h00}    // R6 B->A
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic       rst_n = 1'b0;
   logic [1:0] sel_a = '0, sel_b = '0;
   logic       ld_a_n = 1'b1, rd_a_n = 1'b1, ld_b_n = 1'b1, rd_b_n = 1'b1;
   logic       a_en = 1'b0, b_en = 1'b0;
   logic [7:0] a_val = '0, b_val = '0;
   wire  [7:0] bus_a, bus_b;

   assign bus_a = a_en ? a_val : 8'bz;
   assign bus_b = b_en ? b_val : 8'bz;
   for (genvar i = 0; i < 8; i++) begin : g_pu
      pullup (bus_a[i]);
      pullup (bus_b[i]);
   end

   dual_bus_regset i_dual_bus_regset (
      .rst_n(rst_n), .sel_a(sel_a), .ld_a_n(ld_a_n), .rd_a_n(rd_a_n), .bus_a(bus_a),
      .sel_b(sel_b), .ld_b_n(ld_b_n), .rd_b_n(rd_b_n), .bus_b(bus_b));

   int         n_run = 0, n_fail = 0;
   bit         done = 1'b0;
   logic [7:0] mdl [4];

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] expect_of(input logic [1:0] k, input logic [7:0] v,
                                             input logic [7:0] stored);
      case (k)
         K_LOAD, K_BOTH: return v;
         K_DRIVE:        return stored;
         default:        return REL;
      endcase
   endfunction

   // one bus cycle on both ports
   task automatic op(input logic [1:0] ak, input logic [1:0] ar, input logic [7:0] av,
                     input logic [1:0] bk, input logic [1:0] br, input logic [7:0] bv,
                     input string tag);
      logic [7:0] ea, eb;
      @(negedge clk);
      chk("R4 A released at start", bus_a, REL);
      chk("R4 B released at start", bus_b, REL);
      ea = expect_of(ak, av, mdl[ar]);
      eb = expect_of(bk, bv, mdl[br]);
      sel_a = ar; sel_b = br;
      if (ak == K_LOAD || ak == K_BOTH) begin a_val = av; a_en = 1'b1; ld_a_n = 1'b0; end
      if (ak == K_DRIVE || ak == K_BOTH) rd_a_n = 1'b0;
      if (bk == K_LOAD || bk == K_BOTH) begin b_val = bv; b_en = 1'b1; ld_b_n = 1'b0; end
      if (bk == K_DRIVE || bk == K_BOTH) rd_b_n = 1'b0;
      @(negedge clk);
      chk({tag, " bus A"}, bus_a, ea);
      chk({tag, " bus B"}, bus_b, eb);
      @(negedge clk);
      ld_a_n = 1'b1; ld_b_n = 1'b1;
      if (bk == K_LOAD || bk == K_BOTH) mdl[br] = bv;
      if (ak == K_LOAD || ak == K_BOTH) mdl[ar] = av;   // A wins (R8)
      @(negedge clk);
      a_en = 1'b0; b_en = 1'b0; rd_a_n = 1'b1; rd_b_n = 1'b1;
      @(negedge clk);
      chk("R4 A released at end", bus_a, REL);
      chk("R4 B released at end", bus_b, REL);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      // R10: buses released during reset
      chk("R10 A released in reset", bus_a, REL);
      chk("R10 B released in reset", bus_b, REL);
      rst_n = 1'b1;
      // R10: all words read zero after reset
      for (int i = 0; i < 4; i++) op(K_DRIVE, 2'(i), 8'h00, K_DRIVE, 2'(i), 8'h00, "R10 zero after reset");

      // stimulus table (R1 R2 R3 R6 R7 R11)
      for (int v = 0; v < NVEC; v++) begin
         op(VEC[v][23:22], VEC[v][21:20], VEC[v][19:12],
            VEC[v][11:10], VEC[v][9:8],   VEC[v][7:0], "R6 table");
      end

      // R1 / R5: each code reaches exactly its own word
      for (int i = 0; i < 4; i++) op(K_IDLE, 2'd0, 8'h00, K_LOAD, 2'(i), 8'(8'h80 + i), "R3 fill");
      for (int i = 0; i < 4; i++) op(K_DRIVE, 2'(i), 8'h00, K_IDLE, 2'd0, 8'h00, "R1 R5 code map");

      // R8: both ports load the same word
      op(K_LOAD, 2'd2, 8'h77, K_LOAD, 2'd2, 8'h88, "R8 dual load");
      op(K_DRIVE, 2'd2, 8'h00, K_DRIVE, 2'd2, 8'h00, "R8 port A kept");

      // R9: load and drive together on one port; word 3 holds 0x83
      op(K_BOTH, 2'd3, 8'hA5, K_IDLE, 2'd0, 8'h00, "R9 no self drive");
      op(K_IDLE, 2'd0, 8'h00, K_DRIVE, 2'd3, 8'h00, "R9 loaded value");
      op(K_IDLE, 2'd0, 8'h00, K_BOTH, 2'd1, 8'h3C, "R9 no self drive B");
      op(K_DRIVE, 2'd1, 8'h00, K_IDLE, 2'd0, 8'h00, "R9 loaded value B");

      // R10: reset in mid run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) mdl[i] = '0;
      for (int i = 0; i < 4; i++) op(K_DRIVE, 2'(i), 8'h00, K_DRIVE, 2'(3 - i), 8'h00, "R10 cleared");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule